// File: doc/BRIEF.md
# DTMF Tone Burst Generator

This block turns one decoded keypad entry into a timed pair of tone waveforms for a telephone dialer. It runs from a 3.579545 MHz clock. Each tone comes from an integer divider that steps a 16-step, sine-like staircase. The outputs are two sample codes, one for the low (row) group and one for the high (column) group. An external converter sums them into the line signal.

A start strobe launches a digit. The block then plays a burst of at least 93 ms, followed by a silent gap of at least 93 ms. A busy flag spans both the burst and the gap. Keypad lines arrive as one-hot row and column vectors, so the block can see when two keys are pressed at once. If both keys share a row, only the row tone plays. If both share a column, only the column tone plays. Any other combination starts nothing.

When the tone-mode input is low, which selects pulse dialing, both codes stay at zero. Millisecond timing comes from a prescaler on the same clock, and the prescaler ratio is a parameter so that a test can shorten the timing.

Top module: `dtmf_burst_gen`

## Requirements
- R1: While reset is held and right after it, `busy` is 0 and both `row_code` and `col_code` are 0.
- R2: Row line k (bit k of `row_hot`, k = 0..3) divides the clock by 16 × {320, 292, 264, 236}[k] per staircase cycle, giving about 699, 766, 848 and 948 Hz.
- R3: Column line k (bit k of `col_hot`, k = 0..2) divides the clock by 16 × {184, 168, 152}[k] per staircase cycle, giving about 1216, 1332 and 1472 Hz.
- R4: Within a burst, a tone's code moves through the steps 8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5 and starts at the first of these. Each step lasts one divider reload. The code is 0 whenever that tone is not sounding.
- R5: When the key is released before the minimum, the burst lasts exactly BURST_MS × TICKS_PER_MS clock cycles.
- R6: After each burst, `busy` stays high through a silent gap of exactly GAP_MS × TICKS_PER_MS cycles, and it is never high for fewer than (BURST_MS + GAP_MS) × TICKS_PER_MS cycles.
- R7: While `key_valid` stays high past the minimum, the burst continues. It ends on the first millisecond tick at which the key is released, so its length is a whole number of milliseconds.
- R8: A start strobe that arrives while `busy` is high has no effect, whether it comes during the burst or during the gap.
- R9: While `tone_mode` is 0, a start strobe launches nothing. Dropping `tone_mode` during a burst forces both codes to 0 from the next cycle on.
- R10: With exactly one row line and two or more column lines, only the row tone sounds and `col_code` stays 0.
- R11: With exactly one column line and two or more row lines, only the column tone sounds and `row_code` stays 0.
- R12: A start strobe launches nothing when `key_valid` is 0, when no row line or no column line is set, or when two or more lines are set in both groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_mode | input | 1 | 1 selects tone dialing; 0 selects pulse dialing and silences both tones |
| start | input | 1 | One-cycle strobe that launches a digit |
| key_valid | input | 1 | Key held; sampled at launch and used to extend the burst |
| row_hot | input | 4 | Active row lines, one bit per low-group tone |
| col_hot | input | 3 | Active column lines, one bit per high-group tone |
| row_code | output | 4 | Low-group staircase sample code |
| col_code | output | 4 | High-group staircase sample code |
| busy | output | 1 | High from the start of a burst to the end of its gap |

## Verification
The bench sweeps all twelve single-key row and column pairs. For each pair it measures the spacing between staircase peaks, which tells every divider reload apart from its neighbours. It also records one full staircase to confirm the step order and the starting phase. The bench then plays key presses released early and key presses held long, to separate the fixed minimum burst from the extended burst. It adds strobes during the burst and during the gap, pulse-mode launches, a tone-mode drop in the middle of a burst, and the shared-row, shared-column and unresolvable multi-key patterns. Together these separate dual-tone, single-tone and no-tone outcomes.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int NROW   = 4;
  localparam int NCOL   = 3;
  localparam int CODE_W = 4;
  localparam int STEPS  = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2
  } phase_t;

  // Target frequencies after integer division (Hz).
  function automatic int row_hz(input int idx);
    case (idx)
      0:       return 699;
      1:       return 766;
      2:       return 848;
      default: return 948;
    endcase
  endfunction

  function automatic int col_hz(input int idx);
    case (idx)
      0:       return 1216;
      1:       return 1332;
      default: return 1472;
    endcase
  endfunction

  // Rounded reload: clk / (STEPS * f).
  function automatic int reload_calc(input int clk_hz, input int hz);
    return (clk_hz + (STEPS / 2) * hz) / (STEPS * hz);
  endfunction

  // Sine-like 16-step staircase, never zero while sounding.
  function automatic logic [CODE_W-1:0] wave(input logic [3:0] step);
    case (step)
      4'd0:    return 4'd8;
      4'd1:    return 4'd11;
      4'd2:    return 4'd13;
      4'd3:    return 4'd14;
      4'd4:    return 4'd15;
      4'd5:    return 4'd14;
      4'd6:    return 4'd13;
      4'd7:    return 4'd11;
      4'd8:    return 4'd8;
      4'd9:    return 4'd5;
      4'd10:   return 4'd3;
      4'd11:   return 4'd2;
      4'd12:   return 4'd1;
      4'd13:   return 4'd2;
      4'd14:   return 4'd3;
      default: return 4'd5;
    endcase
  endfunction

endpackage

// File: rtl/dtmf_key_resolve.sv
module dtmf_key_resolve
  import dtmf_pkg::*;
#(
  parameter int NR = NROW,
  parameter int NC = NCOL,
  localparam int RW = $clog2(NR),
  localparam int CW = $clog2(NC),
  localparam int RCW = $clog2(NR + 1),
  localparam int CCW = $clog2(NC + 1)
) (
  input  logic          key_valid,
  input  logic [NR-1:0] row_hot,
  input  logic [NC-1:0] col_hot,
  output logic          key_ok,
  output logic          row_on,
  output logic          col_on,
  output logic [RW-1:0] row_idx,
  output logic [CW-1:0] col_idx
);

  logic [RCW-1:0] n_row;
  logic [CCW-1:0] n_col;
  logic           one_row, one_col, many_row, many_col;

  always_comb begin
    n_row   = '0;
    row_idx = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      n_row = n_row + RCW'(row_hot[i]);
      if (row_hot[i]) row_idx = RW'(i);
    end
  end

  always_comb begin
    n_col   = '0;
    col_idx = '0;
    for (int j = NC - 1; j >= 0; j--) begin
      n_col = n_col + CCW'(col_hot[j]);
      if (col_hot[j]) col_idx = CW'(j);
    end
  end

  assign one_row  = (n_row == RCW'(1));
  assign one_col  = (n_col == CCW'(1));
  assign many_row = (n_row > RCW'(1));
  assign many_col = (n_col > CCW'(1));

  assign row_on = key_valid && one_row && (one_col || many_col);
  assign col_on = key_valid && one_col && (one_row || many_row);
  assign key_ok = row_on || col_on;

endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer
  import dtmf_pkg::*;
#(
  parameter int TICKS_PER_MS = 3580,
  parameter int BURST_MS     = 93,
  parameter int GAP_MS       = 93,
  localparam int PW     = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1,
  localparam int MS_MAX = (BURST_MS > GAP_MS) ? BURST_MS : GAP_MS,
  localparam int MW     = $clog2(MS_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic hold,
  output logic burst_on,
  output logic busy
);

  phase_t        ph_q, ph_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          tick;

  assign tick = (pre_q == PW'(TICKS_PER_MS - 1));

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:  if (launch) ph_d = PH_BURST;
      PH_BURST: if (tick && (ms_q == MW'(BURST_MS - 1)) && !hold) ph_d = PH_GAP;
      PH_GAP:   if (tick && (ms_q == MW'(GAP_MS - 1))) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if ((ph_d != ph_q) || (ph_q == PH_IDLE)) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (tick) begin
      pre_d = '0;
      if (!((ph_q == PH_BURST) && (ms_q == MW'(BURST_MS - 1)))) ms_d = ms_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  assign burst_on = (ph_q == PH_BURST);
  assign busy     = (ph_q != PH_IDLE);

endmodule

// File: rtl/dtmf_tone_div.sv
module dtmf_tone_div
  import dtmf_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic              tone_en,
  input  logic [DIV_W-1:0]  reload_in,
  output logic [CODE_W-1:0] code
);

  logic [DIV_W-1:0]  reload_q;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        step_q, step_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    cnt_d  = cnt_q;
    step_d = step_q;
    if (restart) begin
      cnt_d  = reload_in - 1'b1;
      step_d = '0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_d  = reload_q - 1'b1;
        step_d = step_q + 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    code_d = (run && tone_en) ? wave(step_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      step_q   <= '0;
      code_q   <= '0;
    end else begin
      if (restart) reload_q <= reload_in;
      cnt_q  <= cnt_d;
      step_q <= step_d;
      code_q <= code_d;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ       = 3579545,
  parameter int TICKS_PER_MS = 3580,
  parameter int BURST_MS     = 93,
  parameter int GAP_MS       = 93
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tone_mode,
  input  logic              start,
  input  logic              key_valid,
  input  logic [NROW-1:0]   row_hot,
  input  logic [NCOL-1:0]   col_hot,
  output logic [CODE_W-1:0] row_code,
  output logic [CODE_W-1:0] col_code,
  output logic              busy
);

  localparam int RW    = $clog2(NROW);
  localparam int CW    = $clog2(NCOL);
  localparam int DIV_W = $clog2(reload_calc(CLK_HZ, row_hz(0)) + 1);

  localparam logic [DIV_W-1:0] ROW_REL0 = DIV_W'(reload_calc(CLK_HZ, row_hz(0)));
  localparam logic [DIV_W-1:0] ROW_REL1 = DIV_W'(reload_calc(CLK_HZ, row_hz(1)));
  localparam logic [DIV_W-1:0] ROW_REL2 = DIV_W'(reload_calc(CLK_HZ, row_hz(2)));
  localparam logic [DIV_W-1:0] ROW_REL3 = DIV_W'(reload_calc(CLK_HZ, row_hz(3)));
  localparam logic [DIV_W-1:0] COL_REL0 = DIV_W'(reload_calc(CLK_HZ, col_hz(0)));
  localparam logic [DIV_W-1:0] COL_REL1 = DIV_W'(reload_calc(CLK_HZ, col_hz(1)));
  localparam logic [DIV_W-1:0] COL_REL2 = DIV_W'(reload_calc(CLK_HZ, col_hz(2)));

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic          key_ok, row_on, col_on;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;

  dtmf_key_resolve #(.NR(NROW), .NC(NCOL)) u_resolve (
    .key_valid (key_valid),
    .row_hot   (row_hot),
    .col_hot   (col_hot),
    .key_ok    (key_ok),
    .row_on    (row_on),
    .col_on    (col_on),
    .row_idx   (row_idx),
    .col_idx   (col_idx)
  );

  logic launch, burst_on, busy_w;

  assign launch = start && tone_mode && key_ok && !busy_w;

  dtmf_burst_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .BURST_MS     (BURST_MS),
    .GAP_MS       (GAP_MS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .launch   (launch),
    .hold     (key_valid),
    .burst_on (burst_on),
    .busy     (busy_w)
  );

  // Which tones sound in the current burst.
  logic row_on_q, col_on_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      row_on_q <= 1'b0;
      col_on_q <= 1'b0;
    end else if (launch) begin
      row_on_q <= row_on;
      col_on_q <= col_on;
    end
  end

  logic [DIV_W-1:0] row_rel, col_rel;

  always_comb begin
    case (row_idx)
      2'd0:    row_rel = ROW_REL0;
      2'd1:    row_rel = ROW_REL1;
      2'd2:    row_rel = ROW_REL2;
      default: row_rel = ROW_REL3;
    endcase
    case (col_idx)
      2'd0:    col_rel = COL_REL0;
      2'd1:    col_rel = COL_REL1;
      default: col_rel = COL_REL2;
    endcase
  end

  logic [1:0]             grp_run;
  logic [1:0][DIV_W-1:0]  grp_rel;
  logic [1:0][CODE_W-1:0] grp_code;

  assign grp_run = {burst_on && col_on_q, burst_on && row_on_q};
  assign grp_rel = {col_rel, row_rel};

  for (genvar g = 0; g < 2; g++) begin : g_tone
    dtmf_tone_div #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (srst_n),
      .restart   (launch),
      .run       (grp_run[g]),
      .tone_en   (tone_mode),
      .reload_in (grp_rel[g]),
      .code      (grp_code[g])
    );
  end

  assign row_code = grp_code[0];
  assign col_code = grp_code[1];
  assign busy     = busy_w;

endmodule

// File: rtl/dtmf_burst_gen_chk.sv
module dtmf_burst_gen_chk
  import dtmf_pkg::*;
#(
  parameter int TICKS_PER_MS = 3580,
  parameter int BURST_MS     = 93,
  parameter int GAP_MS       = 93
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tone_mode,
  input logic              start,
  input logic [CODE_W-1:0] row_code,
  input logic [CODE_W-1:0] col_code,
  input logic              busy
);

  localparam int MIN_BUSY = (BURST_MS + GAP_MS) * TICKS_PER_MS;

  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  // R1, R4: silent whenever idle.
  p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (row_code == '0) && (col_code == '0));

  // R6: busy never shorter than burst plus gap minimum.
  p_busy_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q >= 32'(MIN_BUSY)));

  // R8, R12: a burst only begins from a strobe.
  p_launch_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9: pulse mode keeps both codes at zero.
  p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_mode |=> (row_code == '0) && (col_code == '0));

  // R9: no launch in pulse mode.
  p_pulse_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tone_mode) |=> !busy);

  // R5: tone codes appear only inside a busy window.
  p_tone_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_code != '0) || (col_code != '0)) |-> busy);

endmodule

bind dtmf_burst_gen dtmf_burst_gen_chk #(
  .TICKS_PER_MS (TICKS_PER_MS),
  .BURST_MS     (BURST_MS),
  .GAP_MS       (GAP_MS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tone_mode (tone_mode),
  .start     (start),
  .row_code  (row_code),
  .col_code  (col_code),
  .busy      (busy)
);

// File: tb/dtmf_burst_gen_test.sv
module dtmf_burst_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;
  localparam int BMS        = 93;
  localparam int GMS        = 93;
  localparam int BURST_CYC  = BMS * TPM;
  localparam int GAP_CYC    = GMS * TPM;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone_mode = 1'b1;
  logic       start = 1'b0;
  logic       key_valid = 1'b0;
  logic [3:0] row_hot = '0;
  logic [2:0] col_hot = '0;
  logic [3:0] row_code, col_code;
  logic       busy;

  int exp_row_rel [4] = '{320, 292, 264, 236};
  int exp_col_rel [3] = '{184, 168, 152};
  int exp_wave [16]   = '{8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5};

  int n_chk = 0;
  int n_fail = 0;

  dtmf_burst_gen #(
    .CLK_HZ       (3579545),
    .TICKS_PER_MS (TPM),
    .BURST_MS     (BMS),
    .GAP_MS       (GMS)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_mode (tone_mode),
    .start     (start),
    .key_valid (key_valid),
    .row_hot   (row_hot),
    .col_hot   (col_hot),
    .row_code  (row_code),
    .col_code  (col_code),
    .busy      (busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Output monitors, sampled on the falling edge.
  longint cyc = 0;
  int busy_tot = 0, rownz = 0, colnz = 0, anynz = 0;
  int row_pk = 0, col_pk = 0;
  longint row_last = 0, col_last = 0, row_per = 0, col_per = 0;
  logic [3:0] prev_row = '0, prev_col = '0;
  int rlog [64];
  int rlog_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (busy === 1'b1) busy_tot++;
    if (row_code != 0) rownz++;
    if (col_code != 0) colnz++;
    if (row_code != 0 || col_code != 0) anynz++;
    if (row_code == 4'd15 && prev_row != 4'd15) begin
      row_per = cyc - row_last; row_last = cyc; row_pk++;
    end
    if (col_code == 4'd15 && prev_col != 4'd15) begin
      col_per = cyc - col_last; col_last = cyc; col_pk++;
    end
    if (row_code != prev_row && rlog_n < 64) begin
      rlog[rlog_n] = int'(row_code); rlog_n++;
    end
    prev_row = row_code;
    prev_col = col_code;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_true(input string req, input string what, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [3:0] rh, input logic [2:0] ch, input logic kv);
    row_hot   = rh;
    col_hot   = ch;
    key_valid = kv;
    start     = 1'b1;
    step();
    start     = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) step();
    step();
  endtask

  // Launch a key; er/ec are expected row/column tone indices or -1.
  task automatic do_key(input logic [3:0] rh, input logic [2:0] ch, input logic kv,
                        input int er, input int ec, input string req);
    int b0, r0, c0, rp0, cp0;
    b0 = busy_tot; r0 = rownz; c0 = colnz; rp0 = row_pk; cp0 = col_pk;
    launch(rh, ch, kv);
    if (er < 0 && ec < 0) begin
      repeat (30) step();
      key_valid = 1'b0;
      check_eq(req, "no burst busy cycles", busy_tot - b0, 0);
      check_eq(req, "no burst tone cycles", (rownz - r0) + (colnz - c0), 0);
      return;
    end
    while ((er >= 0 && row_pk < rp0 + 2) || (ec >= 0 && col_pk < cp0 + 2)) step();
    key_valid = 1'b0;
    wait_idle();
    if (er >= 0) check_eq(req, $sformatf("row %0d period", er), row_per, 16 * exp_row_rel[er]);
    else         check_eq(req, "row code silent", rownz - r0, 0);
    if (ec >= 0) check_eq(req, $sformatf("col %0d period", ec), col_per, 16 * exp_col_rel[ec]);
    else         check_eq(req, "col code silent", colnz - c0, 0);
    check_true(req, "busy length", (busy_tot - b0) >= BURST_CYC + GAP_CYC,
               busy_tot - b0, BURST_CYC + GAP_CYC);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int b0, n0;
    repeat (3) step();
    check_eq("R1", "busy in reset", busy, 0);
    check_eq("R1", "codes in reset", {row_code, col_code}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "codes after reset", {row_code, col_code}, 0);

    // R4: staircase order from the first step.
    rlog_n = 0;
    do_key(4'b0001, 3'b001, 1'b1, 0, 0, "R4");
    for (int s = 0; s < 16; s++)
      check_eq("R4", $sformatf("step %0d", s), rlog[s], exp_wave[s]);

    // R2 R3: every row/column pair.
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 3; c++)
        do_key(4'(1 << r), 3'(1 << c), 1'b1, r, c, "R2 R3");

    // R5 R6: early release.
    b0 = busy_tot; n0 = anynz;
    launch(4'b0010, 3'b010, 1'b1);
    key_valid = 1'b0;
    wait_idle();
    check_eq("R5", "burst cycles", anynz - n0, BURST_CYC);
    check_eq("R6", "busy cycles", busy_tot - b0, BURST_CYC + GAP_CYC);

    // R7: held key extends the burst to a millisecond boundary.
    n0 = anynz;
    launch(4'b0100, 3'b100, 1'b1);
    repeat (BURST_CYC + 6) step();
    key_valid = 1'b0;
    wait_idle();
    check_true("R7", "extended burst length",
               (anynz - n0) > BURST_CYC && (anynz - n0) <= BURST_CYC + 6 + TPM + 1,
               anynz - n0, BURST_CYC + 8);
    check_eq("R7", "burst length whole ms", (anynz - n0) % TPM, 0);

    // R8: strobes during burst and gap are ignored.
    b0 = busy_tot; n0 = anynz;
    launch(4'b0001, 3'b010, 1'b1);
    key_valid = 1'b0;
    repeat (100) step();
    launch(4'b1000, 3'b100, 1'b1);
    key_valid = 1'b0;
    repeat (BURST_CYC) step();
    launch(4'b1000, 3'b100, 1'b1);
    key_valid = 1'b0;
    wait_idle();
    check_eq("R8", "busy cycles with extra strobes", busy_tot - b0, BURST_CYC + GAP_CYC);
    check_eq("R8", "tone cycles with extra strobes", anynz - n0, BURST_CYC);

    // R9: pulse mode.
    tone_mode = 1'b0;
    b0 = busy_tot; n0 = anynz;
    launch(4'b0001, 3'b001, 1'b1);
    repeat (30) step();
    key_valid = 1'b0;
    check_eq("R9", "pulse mode busy", busy_tot - b0, 0);
    check_eq("R9", "pulse mode tone", anynz - n0, 0);
    tone_mode = 1'b1;
    b0 = busy_tot;
    launch(4'b0010, 3'b010, 1'b1);
    key_valid = 1'b0;
    repeat (60) step();
    tone_mode = 1'b0;
    step();
    n0 = anynz;
    wait_idle();
    check_eq("R9", "tone after mode drop", anynz - n0, 0);
    check_eq("R9", "busy unchanged by mode drop", busy_tot - b0, BURST_CYC + GAP_CYC);
    tone_mode = 1'b1;

    // R10 R11: single-tone fallback.
    do_key(4'b0010, 3'b101, 1'b1, 1, -1, "R10");
    do_key(4'b1001, 3'b010, 1'b1, -1, 1, "R11");

    // R12: unresolvable or invalid keys.
    do_key(4'b0011, 3'b011, 1'b1, -1, -1, "R12");
    do_key(4'b0001, 3'b000, 1'b1, -1, -1, "R12");
    do_key(4'b0000, 3'b001, 1'b1, -1, -1, "R12");
    do_key(4'b0001, 3'b001, 1'b0, -1, -1, "R12");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule